// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable behavioural model of a clocked static RAM with a 64-bit word, sized down to a small depth (256 words by default). All inputs are registered on the rising clock edge. A read returns data from an output register one edge after the input register, so data for an address sampled at edge t is driven after edge t+1. Output drive is gated combinationally by an active-low output enable.

Accesses come in bursts of up to four beats. A burst is opened by either of two active-low address strobes. The processor strobe always reads. The cache strobe reads or writes, depending on the write controls it sees in the same cycle. After a burst opens, each cycle with the advance input low moves a 2-bit beat counter and forms the next address. The order is linear or interleaved, chosen by a mode level that is sampled when the burst opens. Writes are self-timed from the clock and touch any subset of the eight byte lanes. A global-write input forces all eight lanes to be written. A sleep input blocks every access. Access then stays blocked for a fixed two-clock wake-up period, and memory contents are kept.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, drive_o is 0 and rdata_o is 0.
- R2: A read sampled at clock edge t is driven on rdata_o with drive_o = 1 after edge t+1, and not after edge t alone.
- R3: While oe_ni is 1, drive_o is 0 and rdata_o is 0. Lowering oe_ni shows the held read data without waiting for a clock edge.
- R4: With cache_strobe_ni = 0, byte_wr_ni = 0 and global_wr_ni = 1, lane k (bits 8k+7..8k) is written exactly when lane_en_ni[k] = 0. With byte_wr_ni = 1 and global_wr_ni = 1, no lane is written, whatever lane_en_ni holds.
- R5: global_wr_ni = 0 writes all eight lanes, even with lane_en_ni = 8'hFF and byte_wr_ni = 1.
- R6: proc_strobe_ni = 0 starts a read and ignores every write control in that cycle. It takes priority over cache_strobe_ni.
- R7: With order_i = 0 when the burst opens (linear), beat k accesses address {base[7:2], (base[1:0] + k) mod 4}.
- R8: With order_i = 1 when the burst opens (interleaved), beat k accesses address {base[7:2], base[1:0] XOR k}. For example, base 9 gives 9, 8, 11, 10.
- R9: The beat counter is 2 bits wide, so a fifth beat wraps back to the burst start address.
- R10: While sleep_i = 1, no read or write takes place. Memory contents are retained across sleep.
- R11: The first two clock edges after sleep_i falls ignore all accesses. The third edge accepts an access.
- R12: With ce_ni = 1, strobes, advance and write controls are all ignored.
- R13: An advance beat with write controls active writes the current burst address, using that cycle's data and lane enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| proc_strobe_ni | input | 1 | Processor address strobe, active low, always a read |
| cache_strobe_ni | input | 1 | Cache-controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| byte_wr_ni | input | 1 | Gate for the per-lane write enables, active low |
| global_wr_ni | input | 1 | Write all lanes, active low |
| lane_en_ni | input | 8 | Per-lane write enable, active low, bit k covers data bits 8k+7..8k |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Power-down request, active high |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| addr_i | input | 8 | Word address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, 0 while not driven |
| drive_o | output | 1 | High while rdata_o carries valid read data |

## Verification
The assertions check, on every cycle, that nothing is accepted while asleep, during the two wake-up edges or while deselected, that a processor-strobe access never becomes a write, and that every accepted read reaches the output register exactly two edges later. Only the scenarios can show what data comes back. That covers byte-lane merging, the global-write override, the linear and interleaved address sequences with their wrap, advance-beat writes, contents kept across sleep, and the asynchronous output-enable gating, all checked against a reference memory in the bench.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_START_P = 2'd1,
    ACC_START_C = 2'd2,
    ACC_ADV     = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/sram_access_ctl.sv
module sram_access_ctl
  import sram_pkg::*;
#(
  parameter int unsigned LANES    = 8,
  parameter int unsigned WAKE_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             proc_ni,
  input  logic             cache_ni,
  input  logic             adv_ni,
  input  logic             sleep_i,
  input  logic             active_i,
  input  logic             byte_wr_ni,
  input  logic             global_wr_ni,
  input  logic [LANES-1:0] lane_en_ni,
  output acc_kind_e        kind_o,
  output logic             wr_o,
  output logic [LANES-1:0] mask_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0]    wake_q;
  logic             awake;
  logic [LANES-1:0] lane_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= '0;
    else if (sleep_i) wake_q <= CW'(WAKE_CYC);
    else if (wake_q != '0) wake_q <= wake_q - 1'b1;
  end

  assign awake = !sleep_i && (wake_q == '0);

  always_comb begin
    kind_o = ACC_NONE;
    if (awake && !ce_ni) begin
      if (!proc_ni) kind_o = ACC_START_P;
      else if (!cache_ni) kind_o = ACC_START_C;
      else if (!adv_ni && active_i) kind_o = ACC_ADV;
    end
  end

  // global write overrides lane enables; lanes need the gate low
  always_comb begin
    if (!global_wr_ni) lane_mask = '1;
    else if (!byte_wr_ni) lane_mask = ~lane_en_ni;
    else lane_mask = '0;
  end

  assign mask_o = lane_mask;
  assign wr_o   = ((kind_o == ACC_START_C) || (kind_o == ACC_ADV)) && (|lane_mask);
endmodule

// File: rtl/sram_burst_gen.sv
module sram_burst_gen
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              active_o
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q, beat_nxt, lo;
  logic              ord_q, active_q;

  assign beat_nxt = beat_q + BEAT_W'(1);

  always_comb begin
    lo = ord_q ? (base_q[BEAT_W-1:0] ^ beat_nxt) : (base_q[BEAT_W-1:0] + beat_nxt);
    if (kind_i == ACC_ADV) acc_addr_o = {base_q[ADDR_W-1:BEAT_W], lo};
    else acc_addr_o = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      beat_q   <= '0;
      ord_q    <= 1'b1;
      active_q <= 1'b0;
    end else if (kind_i == ACC_START_P || kind_i == ACC_START_C) begin
      base_q   <= addr_i;
      beat_q   <= '0;
      ord_q    <= order_i;
      active_q <= 1'b1;
    end else if (kind_i == ACC_ADV) begin
      beat_q <= beat_nxt;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/sram_core.sv
module sram_core
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W/LANE_W-1:0] mask_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic                     rd_valid_o,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              s1_valid, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [DATA_W-1:0] s1_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_mask  <= '0;
      s1_wdata <= '0;
    end else begin
      s1_valid <= go_i;
      s1_wr    <= wr_i;
      s1_addr  <= addr_i;
      s1_mask  <= mask_i;
      s1_wdata <= wdata_i;
    end
  end

  // self-timed write from the input register
  always_ff @(posedge clk_i) begin
    if (s1_valid && s1_wr) begin
      for (int b = 0; b < LANES; b++) begin
        if (s1_mask[b]) mem[s1_addr][b*LANE_W +: LANE_W] <= s1_wdata[b*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= s1_valid && !s1_wr;
      if (s1_valid && !s1_wr) rd_data_o <= mem[s1_addr];
    end
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned WAKE_CYC = 2,
  localparam int unsigned LANES   = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              proc_strobe_ni,
  input  logic              cache_strobe_ni,
  input  logic              adv_ni,
  input  logic              byte_wr_ni,
  input  logic              global_wr_ni,
  input  logic [LANES-1:0]  lane_en_ni,
  input  logic              order_i,
  input  logic              sleep_i,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  acc_kind_e         acc_kind;
  logic              acc_go, acc_wr, burst_active, rd_valid;
  logic [LANES-1:0]  acc_mask;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] rd_data;

  sram_access_ctl #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) i_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_ni        (ce_ni),
    .proc_ni      (proc_strobe_ni),
    .cache_ni     (cache_strobe_ni),
    .adv_ni       (adv_ni),
    .sleep_i      (sleep_i),
    .active_i     (burst_active),
    .byte_wr_ni   (byte_wr_ni),
    .global_wr_ni (global_wr_ni),
    .lane_en_ni   (lane_en_ni),
    .kind_o       (acc_kind),
    .wr_o         (acc_wr),
    .mask_o       (acc_mask)
  );

  sram_burst_gen #(.ADDR_W(ADDR_W), .BEAT_W(2)) i_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (acc_kind),
    .addr_i     (addr_i),
    .order_i    (order_i),
    .acc_addr_o (acc_addr),
    .active_o   (burst_active)
  );

  assign acc_go = (acc_kind != ACC_NONE);

  sram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (acc_go),
    .wr_i       (acc_wr),
    .addr_i     (acc_addr),
    .mask_i     (acc_mask),
    .wdata_i    (wdata_i),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  assign drive_o = rd_valid && !oe_ni;
  assign rdata_o = drive_o ? rd_data : '0;
endmodule

// File: rtl/sync_burst_sram_checker.sv
module sync_burst_sram_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_ni,
  input logic proc_strobe_ni,
  input logic sleep_i,
  input logic acc_go,
  input logic acc_wr,
  input logic rd_valid
);
  a_r2_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_go && !acc_wr) |-> ##2 rd_valid);

  a_r6_proc_is_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !proc_strobe_ni && acc_go) |-> !acc_wr);

  a_r10_sleep_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !acc_go);

  a_r11_wake_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleep_i) |-> !acc_go);

  a_r11_wake_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleep_i, 2) |-> !acc_go);

  a_r12_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !acc_go);
endmodule

bind sync_burst_sram sync_burst_sram_checker i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ce_ni          (ce_ni),
  .proc_strobe_ni (proc_strobe_ni),
  .sleep_i        (sleep_i),
  .acc_go         (acc_go),
  .acc_wr         (acc_wr),
  .rd_valid       (rd_valid)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni, proc_strobe_ni, cache_strobe_ni, adv_ni;
  logic        byte_wr_ni, global_wr_ni, order_i, sleep_i, oe_ni;
  logic [7:0]  lane_en_ni, addr_i;
  logic [63:0] wdata_i, rdata_o;
  logic        drive_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] ref_m [256];

  always #5 clk_i = ~clk_i;

  sync_burst_sram i_sync_burst_sram (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_ni = 0; proc_strobe_ni = 1; cache_strobe_ni = 1; adv_ni = 1;
    byte_wr_ni = 1; global_wr_ni = 1; lane_en_ni = 8'hFF;
    addr_i = 0; wdata_i = 0;
  endtask

  function automatic logic [63:0] pat(logic [7:0] a, logic [7:0] s);
    return {8{a ^ s}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] d, logic [7:0] m);
    logic [63:0] r = old;
    for (int b = 0; b < 8; b++) if (m[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] exp_addr(logic [7:0] base, int k, logic ord);
    logic [1:0] kk = k[1:0];
    return ord ? {base[7:2], base[1:0] ^ kk} : {base[7:2], base[1:0] + kk};
  endfunction

  // lane-enable write through the cache strobe, one beat
  task automatic wr_lanes(logic [7:0] a, logic [63:0] d, logic [7:0] en_n);
    cache_strobe_ni = 0; byte_wr_ni = 0; lane_en_ni = en_n; addr_i = a; wdata_i = d;
    @(negedge clk_i); idle();
    ref_m[a] = merge(ref_m[a], d, ~en_n);
  endtask

  task automatic wr_global(logic [7:0] a, logic [63:0] d);
    cache_strobe_ni = 0; global_wr_ni = 0; addr_i = a; wdata_i = d;
    @(negedge clk_i); idle();
    ref_m[a] = d;
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    proc_strobe_ni = 0; addr_i = a;
    @(negedge clk_i); idle();
    @(negedge clk_i);
    chk(req, {63'd0, drive_o}, 64'd1);
    chk(req, rdata_o, ref_m[a]);
  endtask

  task automatic t_reset();
    chk("R1 drive", {63'd0, drive_o}, 64'd0);
    chk("R1 rdata", rdata_o, 64'd0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 16; a++) wr_global(8'(a), pat(8'(a), 8'h00));
    for (int a = 0; a < 16; a += 5) rd_chk("R5 fill", 8'(a));
  endtask

  task automatic t_latency();
    @(negedge clk_i);
    proc_strobe_ni = 0; addr_i = 8'd3;
    @(negedge clk_i); idle();
    chk("R2 not yet", {63'd0, drive_o}, 64'd0);
    @(negedge clk_i);
    chk("R2 drive", {63'd0, drive_o}, 64'd1);
    chk("R2 data", rdata_o, ref_m[3]);
  endtask

  task automatic t_oe();
    oe_ni = 1;
    proc_strobe_ni = 0; addr_i = 8'd4;
    @(negedge clk_i); idle();
    @(negedge clk_i);
    chk("R3 no drive", {63'd0, drive_o}, 64'd0);
    chk("R3 zero", rdata_o, 64'd0);
    oe_ni = 0; #1;
    chk("R3 async on", {63'd0, drive_o}, 64'd1);
    chk("R3 data", rdata_o, ref_m[4]);
  endtask

  task automatic t_lanes();
    wr_lanes(8'd5, 64'hFFEE_DDCC_BBAA_9988, 8'b1010_0101);
    rd_chk("R4 lane merge", 8'd5);
    cache_strobe_ni = 0; byte_wr_ni = 1; lane_en_ni = 8'h00; addr_i = 8'd6; wdata_i = '1;
    @(negedge clk_i); idle();
    rd_chk("R4 gate high no write", 8'd6);
  endtask

  task automatic t_global();
    cache_strobe_ni = 0; global_wr_ni = 0; byte_wr_ni = 1; lane_en_ni = 8'hFF;
    addr_i = 8'd7; wdata_i = 64'hA5A5_5A5A_0F0F_F0F0;
    @(negedge clk_i); idle();
    ref_m[7] = 64'hA5A5_5A5A_0F0F_F0F0;
    rd_chk("R5 global all lanes", 8'd7);
  endtask

  task automatic t_proc();
    proc_strobe_ni = 0; cache_strobe_ni = 0; global_wr_ni = 0; addr_i = 8'd2; wdata_i = '0;
    @(negedge clk_i); idle();
    @(negedge clk_i);
    chk("R6 returns read", rdata_o, ref_m[2]);
    rd_chk("R6 no write", 8'd2);
  endtask

  task automatic burst_rd(string req, logic [7:0] base, logic ord, int n);
    for (int k = 0; k < n; k++) begin
      if (k == 0) begin
        proc_strobe_ni = 0; addr_i = base; order_i = ord;
      end else begin
        proc_strobe_ni = 1; adv_ni = 0; order_i = ~ord; addr_i = 8'hFF;
      end
      @(negedge clk_i);
      if (k >= 1) chk(req, rdata_o, ref_m[exp_addr(base, k - 1, ord)]);
    end
    idle(); order_i = 1;
    @(negedge clk_i);
    chk(req, rdata_o, ref_m[exp_addr(base, n - 1, ord)]);
  endtask

  task automatic t_adv_write();
    logic [7:0] base = 8'd13;
    for (int k = 0; k < 4; k++) begin
      if (k == 0) begin
        cache_strobe_ni = 0; addr_i = base; order_i = 1;
      end else begin
        cache_strobe_ni = 1; adv_ni = 0;
      end
      global_wr_ni = 0; wdata_i = pat(8'(k), 8'h3C);
      ref_m[exp_addr(base, k, 1'b1)] = pat(8'(k), 8'h3C);
      @(negedge clk_i);
    end
    idle();
    for (int k = 0; k < 4; k++) rd_chk("R13 adv write", exp_addr(base, k, 1'b1));
  endtask

  task automatic t_sleep();
    sleep_i = 1; proc_strobe_ni = 0; addr_i = 8'd1;
    @(negedge clk_i);
    cache_strobe_ni = 0; proc_strobe_ni = 1; global_wr_ni = 0; addr_i = 8'd0; wdata_i = '1;
    @(negedge clk_i);
    chk("R10 no read while asleep", {63'd0, drive_o}, 64'd0);
    @(negedge clk_i);
    chk("R10 still no read", {63'd0, drive_o}, 64'd0);
    sleep_i = 0; addr_i = 8'd8; wdata_i = '0;
    @(negedge clk_i);
    addr_i = 8'd9;
    @(negedge clk_i); idle();
    rd_chk("R10 contents kept", 8'd0);
    rd_chk("R11 wake edge 1 ignored", 8'd8);
    rd_chk("R11 wake edge 2 ignored", 8'd9);
    sleep_i = 1;
    @(negedge clk_i);
    sleep_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    proc_strobe_ni = 0; addr_i = 8'd10;
    @(negedge clk_i); idle();
    @(negedge clk_i);
    chk("R11 third edge served", rdata_o, ref_m[10]);
  endtask

  task automatic t_deselect();
    ce_ni = 1; cache_strobe_ni = 0; global_wr_ni = 0; addr_i = 8'd11; wdata_i = '0;
    @(negedge clk_i);
    cache_strobe_ni = 1; global_wr_ni = 1; proc_strobe_ni = 0;
    @(negedge clk_i); idle();
    @(negedge clk_i);
    chk("R12 no read", {63'd0, drive_o}, 64'd0);
    rd_chk("R12 no write", 8'd11);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(); order_i = 1; sleep_i = 0; oe_ni = 0;
    for (int i = 0; i < 256; i++) ref_m[i] = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_fill();
    t_latency();
    t_oe();
    t_lanes();
    t_global();
    t_proc();
    burst_rd("R7 linear", 8'd9, 1'b0, 4);
    burst_rd("R8 interleaved", 8'd9, 1'b1, 4);
    burst_rd("R9 wrap", 8'd6, 1'b0, 5);
    t_adv_write();
    t_sleep();
    t_deselect();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule